// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is a small general-purpose I/O port of `N_LINES` lines (eight by default) sitting on a simple APB-style peripheral bus with byte-wide data. It holds an output-value register and a direction register. It drives the pin output values and per-line output enables straight from those registers. Pin inputs pass through a synchronizer before the bus or any neighbouring interrupt block sees them.

The data register appears at every word of a window of addresses. The word-address bits just above the byte offset form a per-line mask. A write changes only the lines whose mask bit is set, and only if those lines are currently outputs. A read returns zero on every line the mask leaves out. Software can therefore update or sample a single pin in one bus access, with no read-modify-write sequence. The direction register sits at one fixed word just above the data window. Every other address reads zero and ignores writes.

A transfer is a setup cycle with `psel` high and `penable` low, followed by an enable cycle with both high. `paddr`, `pwrite` and `pwdata` are held steady over both cycles. A write takes effect at the clock edge that ends the enable cycle. Read data is registered at the end of the setup cycle and is valid during the enable cycle. The two low address bits are ignored.

Top module: `gpio_mask_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `gpio_oe` and `gpio_out` are all zero, and the direction register reads back 0 (all lines inputs).
- R2: A write to the data window (address bits above `N_LINES+1` all zero) updates output bit i only when mask bit i, taken from address bit i+2, is 1. Every other output bit keeps its value, and `gpio_out` changes only after such a write.
- R3: A data write to a line whose direction bit is 0 leaves that line's stored output value unchanged. The value does not appear on the pin when the line is later made an output; it must be written again.
- R4: The direction register is at byte offset `1 << (N_LINES+2)` (0x400 for eight lines). Bit i set to 1 makes line i an output and drives `gpio_oe[i]` high. It reads back as written, and `gpio_oe` changes only after a write to this address.
- R5: A data-window read returns 0 on every bit whose mask bit is 0.
- R6: On a selected bit, a data read returns the stored output value if the line is an output, and the synchronized pin value if it is an input.
- R7: A change on `gpio_in` appears on `gpio_sync` at the second rising clock edge after it is applied, and not at the first.
- R8: A read of any address outside the data window and the direction word returns 0. A write there changes neither `gpio_out`, `gpio_oe` nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Enable (second) cycle of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | N_LINES | Write data |
| prdata | output | N_LINES | Read data, valid in the enable cycle |
| gpio_in | input | N_LINES | Raw pin input values |
| gpio_out | output | N_LINES | Stored output values to the pads |
| gpio_oe | output | N_LINES | Per-line output enable (direction) |
| gpio_sync | output | N_LINES | Synchronized pin values, for the interrupt block |

## Verification
The bench builds the block with its defaults: eight lines, a 12-bit address and two synchronizer stages. With these values the mask occupies address bits 9 to 2, the direction word sits at 0x400, and 0x800 and 0xC04 fall in the unmapped space.

This places every mask pattern and the mapped/unmapped boundary within reach of directed accesses. The bench mixes input and output lines on a single port so that one masked read covers both read sources. It writes to input lines and then turns them into outputs, to show that the earlier write was dropped. It steps a pin change edge by edge through the synchronizer.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_DIR  = 2'd1,
    RGN_NONE = 2'd2
  } region_e;

  typedef struct packed {
    logic    wr;
    logic    rd_setup;
    region_e rgn;
  } access_t;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode #(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = N_LINES + 4
) (
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  output gpio_mask_pkg::access_t      acc,
  output logic [N_LINES-1:0]          mask
);
  import gpio_mask_pkg::*;

  localparam int HI_LSB = N_LINES + 2;
  localparam int HI_W   = ADDR_W - HI_LSB;
  localparam int LOW_W  = HI_LSB - 2;

  logic [HI_W-1:0]  hi;
  logic [LOW_W-1:0] low;

  assign hi   = paddr[ADDR_W-1:HI_LSB];
  assign low  = paddr[HI_LSB-1:2];
  assign mask = paddr[N_LINES+1:2];

  always_comb begin
    acc.wr       = psel && penable && pwrite;
    acc.rd_setup = psel && !penable && !pwrite;
    if (hi == '0)
      acc.rgn = RGN_DATA;
    else if (hi == HI_W'(1) && low == '0)
      acc.rgn = RGN_DIR;
    else
      acc.rgn = RGN_NONE;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] d,
  output logic [N_LINES-1:0] q
);
  logic [N_LINES-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        chain[s] <= '0;
      else if (s == 0)
        chain[s] <= d;
      else
        chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int N_LINES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  gpio_mask_pkg::access_t acc,
  input  logic [N_LINES-1:0]     mask,
  input  logic [N_LINES-1:0]     wdata,
  output logic [N_LINES-1:0]     out_q,
  output logic [N_LINES-1:0]     dir_q
);
  import gpio_mask_pkg::*;

  logic [N_LINES-1:0] upd;

  assign upd = mask & dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (acc.wr) begin
      if (acc.rgn == RGN_DIR)
        dir_q <= wdata;
      if (acc.rgn == RGN_DATA)
        out_q <= (out_q & ~upd) | (wdata & upd);
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
  parameter int N_LINES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  gpio_mask_pkg::access_t acc,
  input  logic [N_LINES-1:0]     mask,
  input  logic [N_LINES-1:0]     out_q,
  input  logic [N_LINES-1:0]     dir_q,
  input  logic [N_LINES-1:0]     pin_s,
  output logic [N_LINES-1:0]     rdata
);
  import gpio_mask_pkg::*;

  logic [N_LINES-1:0] level;
  logic [N_LINES-1:0] nxt;

  assign level = (dir_q & out_q) | (~dir_q & pin_s);

  always_comb begin
    case (acc.rgn)
      RGN_DATA: nxt = level & mask;
      RGN_DIR:  nxt = dir_q;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (acc.rd_setup)
      rdata <= nxt;
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int N_LINES     = 8,
  parameter int ADDR_W      = N_LINES + 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [N_LINES-1:0] pwdata,
  output logic [N_LINES-1:0] prdata,
  input  logic [N_LINES-1:0] gpio_in,
  output logic [N_LINES-1:0] gpio_out,
  output logic [N_LINES-1:0] gpio_oe,
  output logic [N_LINES-1:0] gpio_sync
);
  gpio_mask_pkg::access_t acc;
  logic [N_LINES-1:0]     mask;
  logic [N_LINES-1:0]     out_q;
  logic [N_LINES-1:0]     dir_q;
  logic [N_LINES-1:0]     pin_s;

  gpio_decode #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .acc(acc), .mask(mask)
  );

  gpio_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(gpio_in), .q(pin_s)
  );

  gpio_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .acc(acc), .mask(mask), .wdata(pwdata),
    .out_q(out_q), .dir_q(dir_q)
  );

  gpio_rdmux #(.N_LINES(N_LINES)) u_rd (
    .clk(clk), .rst(rst), .acc(acc), .mask(mask), .out_q(out_q),
    .dir_q(dir_q), .pin_s(pin_s), .rdata(prdata)
  );

  assign gpio_out  = out_q;
  assign gpio_oe   = dir_q;
  assign gpio_sync = pin_s;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = N_LINES + 4
) (
  input logic               clk,
  input logic               rst,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [N_LINES-1:0] prdata,
  input logic [N_LINES-1:0] gpio_out,
  input logic [N_LINES-1:0] gpio_oe
);
  localparam int HI_LSB = N_LINES + 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << HI_LSB;

  logic               wr, rd_en, in_data, at_dir;
  logic [N_LINES-1:0] m;

  assign wr      = psel && penable && pwrite;
  assign rd_en   = psel && penable && !pwrite;
  assign in_data = (paddr >> HI_LSB) == '0;
  assign at_dir  = (paddr >> 2) == (DIR_ADDR >> 2);
  assign m       = paddr[N_LINES+1:2];

  // R1
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (gpio_oe == '0 && gpio_out == '0));

  // R2
  a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(gpio_out));
  a_r2_mask_respected: assert property (@(posedge clk) disable iff (rst)
    wr |=> (((gpio_out ^ $past(gpio_out)) & ~$past(m)) == '0));

  // R3
  a_r3_input_write_dropped: assert property (@(posedge clk) disable iff (rst)
    wr |=> (((gpio_out ^ $past(gpio_out)) & ~$past(gpio_oe)) == '0));

  // R4
  a_r4_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && at_dir) |=> $stable(gpio_oe));

  // R5
  a_r5_unselected_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_data) |-> ((prdata & ~m) == '0));

  // R8
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_data && !at_dir) |-> (prdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;
  localparam int N  = 8;
  localparam int AW = N + 4;
  localparam logic [AW-1:0] DIR_A = 12'h400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [N-1:0]  pwdata = '0;
  logic [N-1:0]  prdata, gpio_out, gpio_oe, gpio_sync;
  logic [N-1:0]  gpio_in = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_mask_port #(.N_LINES(N)) u_gpio_mask_port (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_sync(gpio_sync)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] data_addr(input logic [N-1:0] m);
    return AW'(m) << 2;
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    d = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [N-1:0] r;
    check("R1 oe after reset", gpio_oe, 8'h00);
    check("R1 out after reset", gpio_out, 8'h00);
    bus_read(DIR_A, r);
    check("R1 direction reads 0", r, 8'h00);
  endtask

  task automatic t_direction();
    logic [N-1:0] r;
    bus_write(DIR_A, 8'h0F);
    check("R4 oe follows direction", gpio_oe, 8'h0F);
    bus_read(DIR_A, r);
    check("R4 direction readback", r, 8'h0F);
  endtask

  task automatic t_masked_write();
    bus_write(data_addr(8'hFF), 8'hFF);
    check("R3 only output lines take write", gpio_out, 8'h0F);
    bus_write(data_addr(8'h05), 8'h00);
    check("R2 masked write clears bits 0,2", gpio_out, 8'h0A);
    bus_write(data_addr(8'h02), 8'h00);
    check("R2 single-bit write clears bit 1", gpio_out, 8'h08);
    bus_write(data_addr(8'h00), 8'h00);
    check("R2 empty mask changes nothing", gpio_out, 8'h08);
    bus_write(data_addr(8'h02), 8'hFF);
    check("R2 single-bit write sets bit 1", gpio_out, 8'h0A);
  endtask

  task automatic t_input_dropped();
    bus_write(data_addr(8'hF0), 8'hF0);
    check("R3 write to inputs dropped", gpio_out, 8'h0A);
    bus_write(DIR_A, 8'hFF);
    check("R3 new outputs keep old value", gpio_out, 8'h0A);
    bus_write(data_addr(8'hF0), 8'hA0);
    check("R3 rewrite after direction change", gpio_out, 8'hAA);
    bus_write(DIR_A, 8'h0F);
  endtask

  task automatic t_read_mix();
    logic [N-1:0] r;
    @(negedge clk);
    gpio_in = 8'h5C;
    repeat (3) @(negedge clk);
    bus_read(data_addr(8'hFF), r);
    check("R6 outputs from register, inputs from pins", r, 8'h5A);
    bus_read(data_addr(8'h3C), r);
    check("R5 unselected bits read 0", r, 8'h18);
    bus_read(data_addr(8'h00), r);
    check("R5 empty mask reads 0", r, 8'h00);
  endtask

  task automatic t_sync();
    @(negedge clk);
    gpio_in = 8'hC3;
    @(negedge clk);
    check("R7 not visible after one edge", gpio_sync, 8'h5C);
    @(negedge clk);
    check("R7 visible after two edges", gpio_sync, 8'hC3);
  endtask

  task automatic t_unmapped();
    logic [N-1:0] r;
    bus_write(12'h800, 8'hFF);
    check("R8 unmapped write leaves out", gpio_out, 8'hAA);
    check("R8 unmapped write leaves oe", gpio_oe, 8'h0F);
    bus_write(12'h404, 8'hF0);
    check("R8 write next to direction leaves oe", gpio_oe, 8'h0F);
    bus_read(DIR_A, r);
    check("R8 direction intact", r, 8'h0F);
    bus_read(12'h800, r);
    check("R8 unmapped read 0x800", r, 8'h00);
    bus_read(12'hC04, r);
    check("R8 unmapped read 0xC04", r, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direction();
    t_masked_write();
    t_input_dropped();
    t_read_mix();
    t_sync();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule